// File: doc/BRIEF.md
# Hysteretic Four-Leg Vector Current Controller

This block closes the inner current loop of a four-leg voltage-source inverter. On every sample strobe it takes the reference and the measured current on each of the three stationary-frame axes (alpha, beta, gamma) and forms the error on each axis. Each error drives a pair of two-level hysteretic comparators: one with a wide band, one with a narrow band. The two comparator outputs of an axis together give a three-level demand for that axis: push the current up, leave it alone, or pull it down.

The three demands index a 27-entry selection table. The table returns one of sixteen switching vectors, and each of the vector's four bits drives the upper switch of one inverter leg. One table cell can be met by several vectors. For that cell the wide and narrow comparator levels on alpha and gamma choose among three candidates. When no axis demands a change, the block applies whichever of the two null vectors needs fewer leg transitions from the vector in use.

The band widths are programmable inputs in the same fixed-point scale as the currents. The narrow band is shared by all axes, and each axis has its own wide band. With a scale of 0.01 A per LSB, the usual setting is narrow 20, wide alpha 200, wide beta 800 and wide gamma 500.

Top module: `vcc_vector_ctrl`

## Requirements
- R1: The error on each axis is the reference minus the measured current. It is computed at 17 bits, so the extremes (32767 minus −32768, and −32768 minus 32767) keep their true sign.
- R2: Each two-level comparator goes high when the error is strictly greater than its band. It goes low when the error is strictly less than the negated band. Otherwise it keeps its previous level.
- R3: The three-level state of an axis is +1 when both of its comparators are high, −1 when both are low, and 0 when they differ.
- R4: In `leg_vec`, bit 0 is leg a, bit 1 is leg b, bit 2 is leg c and bit 3 is the neutral leg. A 1 means that leg's upper switch conducts.
- R5: Each state is coded 0 for −1, 1 for 0 and 2 for +1. The table index is 9·gamma + 3·beta + alpha. In index order from 0 to 26 the table gives 12, 12, 13, 14, 8, 9, 10, 10, 11, 4, 4, 13, 14, (null), 1, 2, (tie-break), 11, 4, 5, 5, 6, 7, 1, 2, 3, 3.
- R6: Index 16 is gamma 0, beta +1, alpha 0. At this index the vector is 12 when the wide comparator is high on both alpha and gamma. It is 4 when the alpha wide comparator is high and the gamma wide comparator is low. In every other case it is 13.
- R7: At index 13 (all states 0) the vector is 15 if the vector in use has three or more bits set, and 0 otherwise. A tie at two bits keeps 0.
- R8: The comparators and `leg_vec` change only on a clock edge where `sample_en` is high. Inputs applied while `sample_en` is low have no effect.
- R9: A synchronous active-low reset sets `leg_vec` to 0 and drives every comparator low, so every state reads −1.
- R10: The narrow band is shared by all three axes. Each axis compares against its own wide band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Sample strobe; updates comparators and vector |
| ref_alpha | input | 16 | Reference current, alpha axis, signed |
| ref_beta | input | 16 | Reference current, beta axis, signed |
| ref_gamma | input | 16 | Reference current, gamma axis, signed |
| meas_alpha | input | 16 | Measured current, alpha axis, signed |
| meas_beta | input | 16 | Measured current, beta axis, signed |
| meas_gamma | input | 16 | Measured current, gamma axis, signed |
| band_narrow | input | 16 | Narrow hysteresis band, all axes, unsigned |
| band_wide_alpha | input | 16 | Wide hysteresis band, alpha axis, unsigned |
| band_wide_beta | input | 16 | Wide hysteresis band, beta axis, unsigned |
| band_wide_gamma | input | 16 | Wide hysteresis band, gamma axis, unsigned |
| leg_vec | output | 4 | Selected switching vector {n, c, b, a} |

## Verification
The hardest states to reach from the ports are the split states, where the wide comparator of an axis holds one level while the narrow one holds the other. The tie-break cell needs two of these split states at once, with a chosen polarity on each. The bench reaches them in two steps. It first drives an axis well beyond its wide band so that both comparators agree. It then drives an error that lies between the narrow and the wide band on the opposite side, which flips only the narrow comparator. The null-vector choice is reached the same way, starting from a vector with two bits set and from one with three bits set. Random errors spread around each band then exercise the hysteresis memory over long runs.

// File: rtl/vcc_pkg.sv
// vcc_pkg: shared types and constants for the vector current controller.
// Assumes three stationary axes, indexed alpha=0, beta=1, gamma=2.
package vcc_pkg;

    localparam int NUM_AXES = 3;
    localparam int AX_ALPHA = 0;
    localparam int AX_BETA  = 1;
    localparam int AX_GAMMA = 2;
    localparam int VEC_W    = 4;

    // three-level axis demand; the code is the table digit
    typedef enum logic [1:0] {
        LVL_NEG  = 2'd0,
        LVL_ZERO = 2'd1,
        LVL_POS  = 2'd2
    } lvl_t;

    localparam int TBL_SIZE = 27;
    localparam int IDX_NULL = 9 * 1 + 3 * 1 + 1;   // all demands zero
    localparam int IDX_TIE  = 9 * 1 + 3 * 2 + 1;   // gamma 0, beta +1, alpha 0

    localparam logic [VEC_W-1:0] VEC_NULL_LO = '0;
    localparam logic [VEC_W-1:0] VEC_NULL_HI = '1;

endpackage

// File: rtl/vcc_hyst_cmp.sv
// vcc_hyst_cmp: one two-level hysteretic comparator.
// Presents both the next level (for same-cycle use downstream) and the
// registered level. Assumes band is non-negative; the comparison is strict.
module vcc_hyst_cmp #(
    parameter int ERR_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ERR_W-1:0] err,
    input  logic        [ERR_W-2:0] band,
    output logic                    cmp_d,
    output logic                    cmp_q
);

    logic signed [ERR_W-1:0] lim_pos;
    logic signed [ERR_W-1:0] lim_neg;

    // widen band into the signed error domain
    always_comb begin
        lim_pos = signed'({1'b0, band});
        lim_neg = -lim_pos;
    end

    // next level: set above band, clear below negated band, else hold
    always_comb begin
        if (err > lim_pos) begin
            cmp_d = 1'b1;
        end else if (err < lim_neg) begin
            cmp_d = 1'b0;
        end else begin
            cmp_d = cmp_q;
        end
    end

    // level register, advanced only on the sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
        end else if (upd) begin
            cmp_q <= cmp_d;
        end
    end

endmodule

// File: rtl/vcc_axis_quant.sv
// vcc_axis_quant: error former and three-level quantizer for one axis.
// The three-level demand is the sum of a wide and a narrow comparator.
// Assumes the current inputs are signed two's complement of CUR_W bits.
module vcc_axis_quant
    import vcc_pkg::*;
#(
    parameter int CUR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [CUR_W-1:0] ref_cur,
    input  logic signed [CUR_W-1:0] meas_cur,
    input  logic        [CUR_W-1:0] band_wide,
    input  logic        [CUR_W-1:0] band_narrow,
    output lvl_t                    lvl_d,
    output logic                    wide_d,
    output logic                    wide_q,
    output logic                    narrow_q
);

    localparam int ERR_W = CUR_W + 1;

    logic signed [ERR_W-1:0] err;
    logic                    narrow_d;

    // sign-extended difference, never overflows
    always_comb begin
        err = ERR_W'(ref_cur) - ERR_W'(meas_cur);
    end

    vcc_hyst_cmp #(.ERR_W(ERR_W)) u_wide (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .err   (err),
        .band  (band_wide),
        .cmp_d (wide_d),
        .cmp_q (wide_q)
    );

    vcc_hyst_cmp #(.ERR_W(ERR_W)) u_narrow (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (upd),
        .err   (err),
        .band  (band_narrow),
        .cmp_d (narrow_d),
        .cmp_q (narrow_q)
    );

    // sum of the two comparators mapped onto the demand code
    always_comb begin
        case ({wide_d, narrow_d})
            2'b11:   lvl_d = LVL_POS;
            2'b00:   lvl_d = LVL_NEG;
            default: lvl_d = LVL_ZERO;
        endcase
    end

endmodule

// File: rtl/vcc_vector_select.sv
// vcc_vector_select: maps the three axis demands onto a switching vector.
// Handles the shared tie-break cell and the null-vector choice.
// Assumes cur_vec is the vector currently applied to the legs.
module vcc_vector_select
    import vcc_pkg::*;
(
    input  lvl_t             lvl_alpha,
    input  lvl_t             lvl_beta,
    input  lvl_t             lvl_gamma,
    input  logic             alpha_wide,
    input  logic             gamma_wide,
    input  logic [VEC_W-1:0] cur_vec,
    output logic [VEC_W-1:0] nxt_vec
);

    localparam int IDX_W = $clog2(TBL_SIZE);

    logic [IDX_W-1:0] idx;
    logic [VEC_W-1:0] null_vec;
    logic [VEC_W-1:0] tie_vec;

    // base-3 table index from the three demand digits
    always_comb begin
        idx = IDX_W'(lvl_gamma) * IDX_W'(9)
            + IDX_W'(lvl_beta)  * IDX_W'(3)
            + IDX_W'(lvl_alpha);
    end

    // null vector needing fewer leg transitions; even split keeps low null
    always_comb begin
        if ($countones(cur_vec) > VEC_W / 2) begin
            null_vec = VEC_NULL_HI;
        end else begin
            null_vec = VEC_NULL_LO;
        end
    end

    // tie-break cell resolved by the wide comparators on alpha and gamma
    always_comb begin
        if (alpha_wide && gamma_wide) begin
            tie_vec = 4'd12;
        end else if (alpha_wide) begin
            tie_vec = 4'd4;
        end else begin
            tie_vec = 4'd13;
        end
    end

    // main selection table
    always_comb begin
        case (idx)
            5'd0:    nxt_vec = 4'd12;
            5'd1:    nxt_vec = 4'd12;
            5'd2:    nxt_vec = 4'd13;
            5'd3:    nxt_vec = 4'd14;
            5'd4:    nxt_vec = 4'd8;
            5'd5:    nxt_vec = 4'd9;
            5'd6:    nxt_vec = 4'd10;
            5'd7:    nxt_vec = 4'd10;
            5'd8:    nxt_vec = 4'd11;
            5'd9:    nxt_vec = 4'd4;
            5'd10:   nxt_vec = 4'd4;
            5'd11:   nxt_vec = 4'd13;
            5'd12:   nxt_vec = 4'd14;
            5'd13:   nxt_vec = null_vec;
            5'd14:   nxt_vec = 4'd1;
            5'd15:   nxt_vec = 4'd2;
            5'd16:   nxt_vec = tie_vec;
            5'd17:   nxt_vec = 4'd11;
            5'd18:   nxt_vec = 4'd4;
            5'd19:   nxt_vec = 4'd5;
            5'd20:   nxt_vec = 4'd5;
            5'd21:   nxt_vec = 4'd6;
            5'd22:   nxt_vec = 4'd7;
            5'd23:   nxt_vec = 4'd1;
            5'd24:   nxt_vec = 4'd2;
            5'd25:   nxt_vec = 4'd3;
            5'd26:   nxt_vec = 4'd3;
            default: nxt_vec = cur_vec;
        endcase
    end

endmodule

// File: rtl/vcc_vector_ctrl.sv
// vcc_vector_ctrl: hysteretic vector current controller for a four-leg
// inverter. Three axis quantizers feed a vector selector; the vector
// register advances on sample_en. Assumes band inputs are held stable by
// the surrounding configuration logic.
module vcc_vector_ctrl
    import vcc_pkg::*;
#(
    parameter int CUR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic signed [CUR_W-1:0] ref_alpha,
    input  logic signed [CUR_W-1:0] ref_beta,
    input  logic signed [CUR_W-1:0] ref_gamma,
    input  logic signed [CUR_W-1:0] meas_alpha,
    input  logic signed [CUR_W-1:0] meas_beta,
    input  logic signed [CUR_W-1:0] meas_gamma,
    input  logic        [CUR_W-1:0] band_narrow,
    input  logic        [CUR_W-1:0] band_wide_alpha,
    input  logic        [CUR_W-1:0] band_wide_beta,
    input  logic        [CUR_W-1:0] band_wide_gamma,
    output logic        [VEC_W-1:0] leg_vec
);

    logic signed [CUR_W-1:0] ref_ax   [NUM_AXES];
    logic signed [CUR_W-1:0] meas_ax  [NUM_AXES];
    logic        [CUR_W-1:0] wband_ax [NUM_AXES];
    lvl_t                    lvl_d    [NUM_AXES];
    logic [NUM_AXES-1:0]     wide_d;
    logic [NUM_AXES-1:0]     wide_q_bus;
    logic [NUM_AXES-1:0]     narrow_q_bus;
    logic [VEC_W-1:0]        vec_q;
    logic [VEC_W-1:0]        vec_d;
    logic                    unused_wide_beta;

    // gather per-axis inputs into arrays
    always_comb begin
        ref_ax[AX_ALPHA]   = ref_alpha;
        ref_ax[AX_BETA]    = ref_beta;
        ref_ax[AX_GAMMA]   = ref_gamma;
        meas_ax[AX_ALPHA]  = meas_alpha;
        meas_ax[AX_BETA]   = meas_beta;
        meas_ax[AX_GAMMA]  = meas_gamma;
        wband_ax[AX_ALPHA] = band_wide_alpha;
        wband_ax[AX_BETA]  = band_wide_beta;
        wband_ax[AX_GAMMA] = band_wide_gamma;
    end

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        vcc_axis_quant #(.CUR_W(CUR_W)) u_axis (
            .clk         (clk),
            .rst_n       (rst_n),
            .upd         (sample_en),
            .ref_cur     (ref_ax[g]),
            .meas_cur    (meas_ax[g]),
            .band_wide   (wband_ax[g]),
            .band_narrow (band_narrow),
            .lvl_d       (lvl_d[g]),
            .wide_d      (wide_d[g]),
            .wide_q      (wide_q_bus[g]),
            .narrow_q    (narrow_q_bus[g])
        );
    end

    // the beta wide level only reaches the selector through its demand
    assign unused_wide_beta = wide_d[AX_BETA];

    vcc_vector_select u_select (
        .lvl_alpha  (lvl_d[AX_ALPHA]),
        .lvl_beta   (lvl_d[AX_BETA]),
        .lvl_gamma  (lvl_d[AX_GAMMA]),
        .alpha_wide (wide_d[AX_ALPHA]),
        .gamma_wide (wide_d[AX_GAMMA]),
        .cur_vec    (vec_q),
        .nxt_vec    (vec_d)
    );

    // applied vector, advanced only on the sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= VEC_NULL_LO;
        end else if (sample_en) begin
            vec_q <= vec_d;
        end
    end

    assign leg_vec = vec_q;

endmodule

// File: rtl/vcc_vector_ctrl_chk.sv
// vcc_vector_ctrl_chk: temporal properties of the vector controller,
// bound to the top. Observes the vector and the registered comparators.
module vcc_vector_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sample_en,
    input logic [3:0] leg_vec,
    input logic [2:0] wide_q,
    input logic [2:0] narrow_q
);

    logic all_split;
    logic tie_cell;
    logic all_high;

    // derived views of the comparator state
    always_comb begin
        all_split = ((wide_q ^ narrow_q) == 3'b111);
        all_high  = (wide_q == 3'b111) && (narrow_q == 3'b111);
        tie_cell  = (wide_q[0] ^ narrow_q[0]) && (wide_q[2] ^ narrow_q[2])
                  && wide_q[1] && narrow_q[1];
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (leg_vec == 4'd0 && wide_q == 3'd0 && narrow_q == 3'd0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(leg_vec) && $stable(wide_q) && $stable(narrow_q))); // R8

    AST_NULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        all_split |-> (leg_vec == 4'd0 || leg_vec == 4'd15)); // R7

    AST_NULL_FEW_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (all_split && $past(sample_en)) |-> ($countones(leg_vec ^ $past(leg_vec)) <= 2)); // R7

    AST_TIE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tie_cell |-> (leg_vec == 4'd12 || leg_vec == 4'd4 || leg_vec == 4'd13)); // R6

    AST_ALL_UP: assert property (@(posedge clk) disable iff (!rst_n)
        all_high |-> (leg_vec == 4'd3)); // R5

endmodule

bind vcc_vector_ctrl vcc_vector_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .leg_vec   (leg_vec),
    .wide_q    (wide_q_bus),
    .narrow_q  (narrow_q_bus)
);

// File: tb/vcc_vector_ctrl_tb.sv
`timescale 1ns/1ps
// vcc_vector_ctrl_tb: directed corner cases plus seeded random errors,
// checked against a behavioural model built from the requirements.
module vcc_vector_ctrl_tb;

    localparam int CLK_HALF = 10;   // 50 MHz

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b0;
    logic signed [15:0] ref_a = '0, ref_b = '0, ref_g = '0;
    logic signed [15:0] meas_a = '0, meas_b = '0, meas_g = '0;
    logic        [15:0] bn = 16'd20, bwa = 16'd200, bwb = 16'd800, bwg = 16'd500;
    logic        [3:0]  leg_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    bit       m_w [3];
    bit       m_n [3];
    logic [3:0] m_vec = 4'd0;

    localparam int TBL [27] = '{12, 12, 13, 14, 8, 9, 10, 10, 11,
                                4, 4, 13, 14, -1, 1, 2, -1, 11,
                                4, 5, 5, 6, 7, 1, 2, 3, 3};

    always #CLK_HALF clk = ~clk;

    vcc_vector_ctrl u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sample_en       (sample_en),
        .ref_alpha       (ref_a),
        .ref_beta        (ref_b),
        .ref_gamma       (ref_g),
        .meas_alpha      (meas_a),
        .meas_beta       (meas_b),
        .meas_gamma      (meas_g),
        .band_narrow     (bn),
        .band_wide_alpha (bwa),
        .band_wide_beta  (bwb),
        .band_wide_gamma (bwg),
        .leg_vec         (leg_vec)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: leg_vec=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 3; k++) begin
            m_w[k] = 0;
            m_n[k] = 0;
        end
        m_vec = 4'd0;
    endtask

    // model of one strobe, from R1..R7 and R10
    task automatic model_step(input int ea, input int eb, input int eg);
        int e [3];
        int wb [3];
        int lv [3];
        int idx;
        e[0] = ea; e[1] = eb; e[2] = eg;
        wb[0] = int'(bwa); wb[1] = int'(bwb); wb[2] = int'(bwg);
        for (int k = 0; k < 3; k++) begin
            if (e[k] > wb[k]) m_w[k] = 1; else if (e[k] < -wb[k]) m_w[k] = 0;
            if (e[k] > int'(bn)) m_n[k] = 1; else if (e[k] < -int'(bn)) m_n[k] = 0;
            lv[k] = (m_w[k] && m_n[k]) ? 2 : ((!m_w[k] && !m_n[k]) ? 0 : 1);
        end
        idx = 9 * lv[2] + 3 * lv[1] + lv[0];
        if (idx == 13) begin
            m_vec = ($countones(m_vec) >= 3) ? 4'd15 : 4'd0;
        end else if (idx == 16) begin
            if (m_w[0] && m_w[2]) m_vec = 4'd12;
            else if (m_w[0]) m_vec = 4'd4;
            else m_vec = 4'd13;
        end else begin
            m_vec = 4'(TBL[idx]);
        end
    endtask

    // drive at negedge, clock once, check point is the following negedge
    task automatic step(input logic en, input int ra, input int ma, input int rb,
                        input int mb, input int rg, input int mg);
        sample_en = en;
        ref_a = 16'(ra); meas_a = 16'(ma);
        ref_b = 16'(rb); meas_b = 16'(mb);
        ref_g = 16'(rg); meas_g = 16'(mg);
        @(posedge clk);
        if (en) model_step(ra - ma, rb - mb, rg - mg);
        @(negedge clk);
    endtask

    task automatic stepe(input logic en, input int ea, input int eb, input int eg);
        step(en, ea, 0, eb, 0, eg, 0);
    endtask

    function automatic int rnd_err(input int wb);
        int span;
        span = wb + int'(bn) + 40;
        return int'($urandom_range(0, 2 * span)) - span;
    endfunction

    task automatic random_phase(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            int ma, mb, mg;
            logic en;
            en = ($urandom_range(0, 3) != 0);
            ma = int'($urandom_range(0, 40000)) - 20000;
            mb = int'($urandom_range(0, 40000)) - 20000;
            mg = int'($urandom_range(0, 40000)) - 20000;
            step(en, ma + rnd_err(int'(bwa)), ma, mb + rnd_err(int'(bwb)), mb,
                 mg + rnd_err(int'(bwg)), mg);
            chk("R5 random vs model", leg_vec, m_vec);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        chk("R9 vector after reset", leg_vec, 4'd0);
        rst_n = 1'b1;

        // comparators start low: zero error holds them, all demands -1
        stepe(1, 0, 0, 0);
        chk("R9 comparators cleared by reset", leg_vec, 4'd12);

        // 300 clears only the alpha wide band: alpha +1, beta/gamma split
        stepe(1, 300, 300, 300);
        chk("R10 per-axis wide bands / R3", leg_vec, 4'd1);

        stepe(0, -5000, -5000, -5000);
        chk("R8 idle strobe ignored", leg_vec, 4'd1);
        stepe(1, 0, 0, 0);
        chk("R8 comparators untouched while idle", leg_vec, 4'd1);

        // alpha between narrow and wide on the low side: only narrow flips
        stepe(1, -150, 0, 0);
        chk("R2 narrow-only flip gives null from one-bit vector (R7)", leg_vec, 4'd0);

        stepe(1, 1000, 1000, 1000);
        chk("R5 all demands up", leg_vec, 4'd3);

        stepe(1, -30, -30, -30);
        chk("R7 null tie at two bits keeps 0", leg_vec, 4'd0);

        stepe(1, 0, 0, 1000);
        chk("R4 gamma up alone gives legs a,b,c high", leg_vec, 4'b0111);

        stepe(1, 0, 0, -30);
        chk("R7 null from three-bit vector", leg_vec, 4'd15);

        stepe(1, 0, 1000, 0);
        chk("R6 alpha and gamma wide high", leg_vec, 4'd12);

        stepe(1, 0, 0, -1000);
        chk("R5 index 7", leg_vec, 4'd10);
        stepe(1, 0, 0, 30);
        chk("R6 gamma wide low", leg_vec, 4'd4);

        stepe(1, -1000, 0, 0);
        chk("R5 index 15", leg_vec, 4'd2);
        stepe(1, 30, 0, 0);
        chk("R6 alpha wide low", leg_vec, 4'd13);

        step(1, 32767, -32768, 32767, -32768, 32767, -32768);
        chk("R1 largest positive error", leg_vec, 4'd3);
        step(1, -32768, 32767, -32768, 32767, -32768, 32767);
        chk("R1 largest negative error", leg_vec, 4'd12);

        if (m_vec !== 4'd12) begin
            n_fail++;
            $display("FAIL R5 model desync: model=%0d expected 12", m_vec);
        end

        random_phase(3000);
        bn = 16'd5; bwa = 16'd50; bwb = 16'd60; bwg = 16'd70;
        random_phase(3000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule